// File: doc/BRIEF.md
# Low-Order Interleaved Banked Memory

This block is a word-addressed memory split into several independent banks. Each bank has its own storage and its own occupancy timer. A single request port with a valid/ready handshake takes reads and writes. The address is decoded into a bank and a row. By default the bank comes from the lowest address bits, so consecutive words rotate through the banks. A mode input switches to block granularity instead: runs of B consecutive words stay together in one bank, and successive blocks rotate through the banks.

A request is taken only when the bank it targets is idle. While the bank is occupied, the port holds ready low. Streams that spread over the banks therefore overlap their accesses, and streams that keep hitting one bank run at that bank's own rate. Every read returns its data a fixed number of cycles after acceptance, in acceptance order. A write changes storage when it is accepted and returns nothing.

Top module: `ilv_mem`

## Requirements
- R1: With `map_mode` = 0 (word mapping), address A is stored in bank A mod M at row floor(A / M). With M = 4, a word written at address 6 lives in bank 2, row 1.
- R2: A stream of consecutive word addresses in word mapping, with ACCESS_CYC = M = 4, is accepted at one request per cycle with no stall.
- R3: With `map_mode` = 1 (block mapping), the bank is floor(A / B) mod M and the row is floor(A / (B*M)) * B + (A mod B). With M = B = 4, block address 9 reaches the same storage word as word address 6, and block address 20 the same as word address 17.
- R4: A request whose bank is still occupied is held: `req_ready` stays low and the request is not accepted. A stride-M word stream, or four addresses inside one block in block mode, is therefore limited to one acceptance every ACCESS_CYC cycles.
- R5: A bank becomes free exactly ACCESS_CYC cycles after it accepted a request. The next request to it is accepted on that edge and no earlier.
- R6: Read data appears with `rsp_valid` high exactly ACCESS_CYC clock edges after the edge that accepted the read.
- R7: Read responses come back in acceptance order and carry the most recently written value of the addressed word.
- R8: A write produces no response. A later read of the same address returns the written value.
- R9: Reset clears every bank's occupancy and all pending responses. After reset `req_ready` is high for any address and `rsp_valid` stays low until a new read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 1 | 0 = word mapping, 1 = block mapping |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | High when the addressed bank is idle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The assertions check cycle properties on every clock. No bank accepts a request while it is occupied. An accepting bank reports occupancy on the next cycle exactly when the access time exceeds one. A response never appears without an outstanding read. The number of reads in flight stays within the latency bound, and the response strobe is quiet after reset. The exact address-to-bank and address-to-row mapping, the acceptance spacing of sequential, strided and same-block streams, the latency, the data ordering and the write-then-read values can only be shown by the bench scenarios. Those scenarios compare the port against an independent model.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    MAP_WORD  = 1'b0,
    MAP_BLOCK = 1'b1
  } map_mode_e;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
  parameter int ADDR_W      = 10,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 4
) (
  input  logic                               blk_sel,
  input  logic [ADDR_W-1:0]                  addr,
  output logic [$clog2(NUM_BANKS)-1:0]       bank,
  output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] row
);
  localparam int BK_W  = $clog2(NUM_BANKS);
  localparam int BLK_W = $clog2(BLOCK_WORDS);
  localparam int ROW_W = ADDR_W - BK_W;

  logic [ADDR_W-1:0] blk_num, blk_row, wrd_row, in_blk;

  always_comb begin
    wrd_row = addr >> BK_W;
    blk_num = addr >> BLK_W;
    in_blk  = addr & ADDR_W'(BLOCK_WORDS - 1);
    blk_row = ((addr >> (BLK_W + BK_W)) << BLK_W) | in_blk;
    if (blk_sel == ilv_pkg::MAP_BLOCK) begin
      bank = blk_num[BK_W-1:0];
      row  = blk_row[ROW_W-1:0];
    end else begin
      bank = addr[BK_W-1:0];
      row  = wrd_row[ROW_W-1:0];
    end
  end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ROW_W      = 8,
  parameter int DATA_W     = 16,
  parameter int ACCESS_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 2 ** ROW_W;
  localparam int CW   = (ACCESS_CYC > 1) ? $clog2(ACCESS_CYC) : 1;

  logic [DATA_W-1:0] store [ROWS];
  logic [CW-1:0]     remain;

  // storage: single-port, registered read, block-RAM friendly
  always_ff @(posedge clk) begin
    if (acc) begin
      if (we) store[row] <= wdata;
      else    rdata      <= store[row];
    end
  end

  // occupancy timer
  always_ff @(posedge clk) begin
    if (rst)                 remain <= '0;
    else if (acc)            remain <= CW'(ACCESS_CYC - 1);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  AST_NO_BUSY_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc |-> !busy); // R4

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc |=> (busy == (ACCESS_CYC > 1))); // R5
endmodule

// File: rtl/ilv_return_pipe.sv
module ilv_return_pipe #(
  parameter int BK_W       = 2,
  parameter int ACCESS_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [BK_W-1:0] push_bank,
  output logic            out_valid,
  output logic [BK_W-1:0] out_bank
);
  logic            stg_v [ACCESS_CYC];
  logic [BK_W-1:0] stg_b [ACCESS_CYC];

  always_ff @(posedge clk) begin
    stg_b[0] <= push_bank;
    for (int i = 1; i < ACCESS_CYC; i++) stg_b[i] <= stg_b[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ACCESS_CYC; i++) stg_v[i] <= 1'b0;
    end else begin
      stg_v[0] <= push;
      for (int i = 1; i < ACCESS_CYC; i++) stg_v[i] <= stg_v[i-1];
    end
  end

  assign out_valid = stg_v[ACCESS_CYC-1];
  assign out_bank  = stg_b[ACCESS_CYC-1];
endmodule

// File: rtl/ilv_mem.sv
module ilv_mem #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int ACCESS_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int BK_W  = $clog2(NUM_BANKS);
  localparam int ROW_W = ADDR_W - BK_W;
  localparam int OW    = $clog2(ACCESS_CYC + 3);

  logic [BK_W-1:0]      sel_bank;
  logic [ROW_W-1:0]     sel_row;
  logic [NUM_BANKS-1:0] bank_busy;
  logic [NUM_BANKS-1:0] bank_acc;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
  logic                 accept;
  logic                 ret_valid;
  logic [BK_W-1:0]      ret_bank;

  ilv_addr_map #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BLOCK_WORDS(BLOCK_WORDS)
  ) u_map (
    .blk_sel(map_mode), .addr(req_addr), .bank(sel_bank), .row(sel_row)
  );

  assign req_ready = ~bank_busy[sel_bank];
  assign accept    = req_valid & req_ready;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_acc[g] = accept && (sel_bank == BK_W'(g));
    ilv_bank #(
      .ROW_W(ROW_W), .DATA_W(DATA_W), .ACCESS_CYC(ACCESS_CYC)
    ) u_bank (
      .clk(clk), .rst(rst), .acc(bank_acc[g]), .we(req_write),
      .row(sel_row), .wdata(req_wdata), .busy(bank_busy[g]),
      .rdata(bank_rd[g])
    );
  end

  ilv_return_pipe #(.BK_W(BK_W), .ACCESS_CYC(ACCESS_CYC)) u_ret (
    .clk(clk), .rst(rst), .push(accept & ~req_write), .push_bank(sel_bank),
    .out_valid(ret_valid), .out_bank(ret_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= ret_valid;
  end

  always_ff @(posedge clk) begin
    rsp_rdata <= bank_rd[ret_bank];
  end

  // reads accepted but not yet seen on the response port
  logic [OW-1:0] in_flight;
  always_ff @(posedge clk) begin
    if (rst) in_flight <= '0;
    else     in_flight <= in_flight + OW'(accept & ~req_write) - OW'(rsp_valid);
  end

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (in_flight != '0)); // R8

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    in_flight <= OW'(ACCESS_CYC + 1)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid); // R9
endmodule

// File: tb/ilv_mem_test.sv
module ilv_mem_test;
  localparam int AW = 10, DW = 16, M = 4, B = 4, TM = 4;

  logic clk = 1'b0, rst = 1'b1, map_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;

  ilv_mem #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(M), .BLOCK_WORDS(B),
            .ACCESS_CYC(TM)) uut (
    .clk(clk), .rst(rst), .map_mode(map_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [int];
  logic [DW-1:0] exp_data [$];
  int            exp_edge [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int loc(input int a, input bit blk);
    int bk, rw;
    if (blk) begin
      bk = (a / B) % M;
      rw = (a / (B * M)) * B + (a % B);
    end else begin
      bk = a % M;
      rw = a / M;
    end
    return bk * 100000 + rw;
  endfunction

  // driver: returns the edge number that accepts the request
  task automatic send(input bit we, input int a, input int d, output int acc_edge);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = AW'(a); req_wdata = DW'(d);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_edge = cyc + 1;
    k = loc(a, map_mode);
    if (we) model[k] = DW'(d);
    else begin
      exp_data.push_back(model.exists(k) ? model[k] : 'x);
      exp_edge.push_back(acc_edge + TM);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_data.size() == 0) check(1'b0, "R8 unexpected response", 1, 0);
      else begin
        logic [DW-1:0] d; int e;
        d = exp_data.pop_front(); e = exp_edge.pop_front();
        check(rsp_rdata === d, "R7 read data", int'(rsp_rdata), int'(d));
        check(cyc == e, "R6 response edge", cyc, e);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    int e0, e1, prev;
    repeat (3) @(negedge clk);
    #1; check(req_ready === 1'b1, "R9 ready in reset", req_ready, 1);
    check(rsp_valid === 1'b0, "R9 rsp low in reset", rsp_valid, 0);
    rst = 1'b0;

    // R2 sequential writes (no responses expected, R8)
    send(1, 0, 16'hA000, prev); e0 = prev;
    for (int a = 1; a < 16; a++) send(1, a, 16'hA000 + a, prev);
    check(prev - e0 == 15, "R2 sequential writes spacing", prev - e0, 15);

    // R2/R1 sequential reads
    send(0, 0, 0, prev); e0 = prev;
    for (int a = 1; a < 16; a++) begin
      send(0, a, 0, e1);
      check(e1 - prev == 1, "R2 sequential read spacing", e1 - prev, 1);
      prev = e1;
    end

    // R4/R5 stride-M stream
    repeat (TM) @(negedge clk);
    send(0, 0, 0, prev);
    for (int a = 4; a < 16; a += 4) begin
      send(0, a, 0, e1);
      check(e1 - prev == TM, "R4 R5 stride spacing", e1 - prev, TM);
      prev = e1;
    end

    // R1/R3 aliasing between mappings
    send(1, 6, 16'h1606, prev);
    send(1, 17, 16'h1717, prev);
    repeat (TM) @(negedge clk);
    map_mode = 1'b1;
    send(0, 9, 0, prev);
    send(0, 20, 0, prev);

    // R3 block mode: one block lives in one bank
    repeat (TM) @(negedge clk);
    send(0, 8, 0, prev);
    for (int a = 9; a < 12; a++) begin
      send(0, a, 0, e1);
      check(e1 - prev == TM, "R3 same-block spacing", e1 - prev, TM);
      prev = e1;
    end
    map_mode = 1'b0;

    // R8 write then read same word
    repeat (TM) @(negedge clk);
    send(1, 3, 16'hBEEF, prev);
    send(0, 3, 0, e1);
    check(e1 - prev == TM, "R5 write-read spacing", e1 - prev, TM);

    // drain
    repeat (2 * TM + 2) @(negedge clk);
    check(exp_data.size() == 0, "R7 all responses seen", exp_data.size(), 0);

    // R9 reset in flight
    send(0, 0, 0, prev);
    @(negedge clk); rst = 1'b1;
    exp_data.delete(); exp_edge.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    req_addr = '0; #1;
    check(req_ready === 1'b1, "R9 bank free after reset", req_ready, 1);
    for (int i = 0; i < TM + 2; i++) begin
      @(negedge clk);
      check(rsp_valid === 1'b0, "R9 no stale response", rsp_valid, 0);
    end
    summary();
  end
endmodule